// File: doc/BRIEF.md
# PWM Output Action Qualifier with Shadowed Software Force

This block turns the event strobes of a PWM time base into the level of one PWM pin. On each time-base tick the block looks at which events fired (counter at zero, counter at period, compare A matched while counting up, compare B matched while counting up). It reads a 2-bit action for each event from a 16-bit action word, and holds, clears, sets or toggles its registered output to match. Normal or inverted polarity is just a choice of action word.

Software can also pin the output to a fixed level through a continuous-force field. A write to that field lands in a shadow copy. The shadow copy becomes the active copy only at a reload point: counter zero, counter period, either of them, or the next tick. A reload-mode register selects which. While a force is active it overrides every event action. The parameter `CHAN_SEL` picks which force field the instance obeys: channel A or channel B.

Top module: `pwm_action_qual`

## Requirements
- R1: After reset `pwm_out` is 0, every action field reads as no action (00), and no force is active, active or shadowed.
- R2: On a tick with a single event and no active force, the event's 2-bit action sets the next output. 00 holds it, 01 drives 0, 10 drives 1 and 11 inverts it. The output register updates on the clock edge where `tb_tick` is 1.
- R3: The action word holds the action for the zero event in bits 1:0, for the period event in bits 3:2, for compare-A-up in bits 5:4 and for compare-B-up in bits 9:8. Bits 7:6 and 15:10 have no effect.
- R4: Event strobes on a cycle where `tb_tick` is 0 leave the output unchanged.
- R5: When several events fire on one tick, only the asserted event with the highest rank applies its action, even when that action is 00. The ranking from highest to lowest is compare B, compare A, period, zero.
- R6: Each force field is 2 bits. 01 forces 0, 10 forces 1, and 00 and 11 mean no force. Channel A uses bits 1:0 of the force word and channel B uses bits 3:2.
- R7: A force write changes only the shadow copy. The output stays under event control until the selected reload point moves the shadow copy into the active copy.
- R8: The reload mode is taken from bits 7:6 of the reload word. 00 reloads on a tick with the zero event, 01 on a tick with the period event, 10 on a tick with either, and 11 on the very next tick. The output level set on the reload tick already obeys the newly loaded force.
- R9: While a force is active, the output holds the forced level on every tick, whatever events fire.
- R10: When a no-force code is reloaded, event actions take control again from that tick on.
- R11: Action word 0x001A gives normal polarity: the output goes high at zero and at period, and low at compare A up. Word 0x0025 gives the complementary output for the same event sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tb_tick | input | 1 | Time-base tick enable; events count only when this is 1 |
| ev_zero | input | 1 | Counter reached zero |
| ev_period | input | 1 | Counter reached period |
| ev_cmpa_up | input | 1 | Compare A match while counting up |
| ev_cmpb_up | input | 1 | Compare B match while counting up |
| act_wr | input | 1 | Write strobe for the action word |
| act_wdata | input | 16 | Action word data |
| frc_wr | input | 1 | Write strobe for the force word (shadow copy) |
| frc_wdata | input | 16 | Force word data |
| rld_wr | input | 1 | Write strobe for the reload word |
| rld_wdata | input | 16 | Reload word data; bits 7:6 hold the reload mode |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The bench builds two copies side by side on shared inputs: one with `CHAN_SEL` = 0 and one with `CHAN_SEL` = 1. A single force write can then show each channel obeying its own field and ignoring the other. With four events and four codes, the bench can sweep every event against every code from both starting levels. It can also sweep all fifteen combinations of coincident events and run every reload mode against every force code, comparing each tick with a bench-side reference model.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    RLD_ZERO   = 2'b00,
    RLD_PERIOD = 2'b01,
    RLD_EITHER = 2'b10,
    RLD_NOW    = 2'b11
  } rld_e;

  localparam int NUM_EV   = 4;   // zero, period, cmpa, cmpb, rising rank
  localparam int FLD_W    = 2;
  localparam int RLD_LSB  = 6;
  localparam int FRC_STEP = 2;

  // bit offset of each event's action field in the action word
  function automatic int ev_field_lsb(input int idx);
    case (idx)
      0:       return 0;
      1:       return 2;
      2:       return 4;
      default: return 8;
    endcase
  endfunction

  function automatic logic apply_action(input logic cur, input act_e a);
    case (a)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

  function automatic logic force_valid(input logic [1:0] code);
    return code == 2'b01 || code == 2'b10;
  endfunction

  function automatic logic force_level(input logic [1:0] code);
    return code == 2'b10;
  endfunction

  function automatic logic reload_hit(input rld_e m, input logic z, input logic p);
    case (m)
      RLD_ZERO:   return z;
      RLD_PERIOD: return p;
      RLD_EITHER: return z | p;
      default:    return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/aq_event_sel.sv
module aq_event_sel
  import pwm_aq_pkg::*;
#(
  parameter int CTL_W = 16
) (
  input  logic [CTL_W-1:0]  ctl,
  input  logic [NUM_EV-1:0] ev,
  output act_e              win_code,
  output logic              any_ev
);

  logic [FLD_W-1:0] field [NUM_EV];

  generate
    for (genvar g = 0; g < NUM_EV; g++) begin : g_fld
      assign field[g] = ctl[ev_field_lsb(g) +: FLD_W];
    end
  endgenerate

  // higher index overrides lower: cmpb > cmpa > period > zero
  always_comb begin
    win_code = ACT_NONE;
    for (int i = 0; i < NUM_EV; i++) begin
      if (ev[i]) win_code = act_e'(field[i]);
    end
  end

  assign any_ev = |ev;

endmodule

// File: rtl/aq_force_ctrl.sv
module aq_force_ctrl
  import pwm_aq_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int CHAN_SEL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ev_zero,
  input  logic             ev_period,
  input  logic             frc_wr,
  input  logic [REG_W-1:0] frc_wdata,
  input  logic             rld_wr,
  input  logic [REG_W-1:0] rld_wdata,
  output logic [1:0]       frc_shadow,
  output logic [1:0]       frc_active,
  output rld_e             rld_mode,
  output logic             load,
  output logic [1:0]       eff_code
);

  localparam int FRC_LSB = CHAN_SEL * FRC_STEP;

  logic [1:0] wr_field;

  generate
    if (CHAN_SEL == 0) begin : g_chan_a
      assign wr_field = frc_wdata[1:0];
    end else begin : g_chan_b
      assign wr_field = frc_wdata[FRC_LSB +: FLD_W];
    end
  endgenerate

  assign load     = tick && reload_hit(rld_mode, ev_zero, ev_period);
  assign eff_code = load ? frc_shadow : frc_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_mode <= RLD_ZERO;
    end else if (rld_wr) begin
      rld_mode <= rld_e'(rld_wdata[RLD_LSB +: FLD_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frc_shadow <= 2'b00;
    end else if (frc_wr) begin
      frc_shadow <= wr_field;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frc_active <= 2'b00;
    end else if (load) begin
      frc_active <= frc_shadow;
    end
  end

endmodule

// File: rtl/aq_out_stage.sv
module aq_out_stage
  import pwm_aq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  act_e       win_code,
  input  logic [1:0] eff_code,
  output logic       eff_valid,
  output logic       eff_level,
  output logic       pwm_q
);

  logic nxt;

  assign eff_valid = force_valid(eff_code);
  assign eff_level = force_level(eff_code);
  assign nxt       = eff_valid ? eff_level : apply_action(pwm_q, win_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
    end else if (tick) begin
      pwm_q <= nxt;
    end
  end

endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
  import pwm_aq_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int CHAN_SEL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tb_tick,
  input  logic             ev_zero,
  input  logic             ev_period,
  input  logic             ev_cmpa_up,
  input  logic             ev_cmpb_up,
  input  logic             act_wr,
  input  logic [REG_W-1:0] act_wdata,
  input  logic             frc_wr,
  input  logic [REG_W-1:0] frc_wdata,
  input  logic             rld_wr,
  input  logic [REG_W-1:0] rld_wdata,
  output logic             pwm_out
);

  logic [REG_W-1:0]  act_ctl;
  logic [NUM_EV-1:0] ev_vec;
  act_e              win_code;
  logic              any_ev;
  logic [1:0]        frc_shadow;
  logic [1:0]        frc_active;
  rld_e              rld_mode;
  logic              load;
  logic [1:0]        eff_code;
  logic              eff_valid;
  logic              eff_level;

  assign ev_vec = {ev_cmpb_up, ev_cmpa_up, ev_period, ev_zero};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_ctl <= '0;
    end else if (act_wr) begin
      act_ctl <= act_wdata;
    end
  end

  aq_event_sel #(.CTL_W(REG_W)) u_sel (
    .ctl      (act_ctl),
    .ev       (ev_vec),
    .win_code (win_code),
    .any_ev   (any_ev)
  );

  aq_force_ctrl #(.REG_W(REG_W), .CHAN_SEL(CHAN_SEL)) u_frc (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tb_tick),
    .ev_zero    (ev_zero),
    .ev_period  (ev_period),
    .frc_wr     (frc_wr),
    .frc_wdata  (frc_wdata),
    .rld_wr     (rld_wr),
    .rld_wdata  (rld_wdata),
    .frc_shadow (frc_shadow),
    .frc_active (frc_active),
    .rld_mode   (rld_mode),
    .load       (load),
    .eff_code   (eff_code)
  );

  aq_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tb_tick),
    .win_code  (win_code),
    .eff_code  (eff_code),
    .eff_valid (eff_valid),
    .eff_level (eff_level),
    .pwm_q     (pwm_out)
  );

endmodule

// File: rtl/aq_checker.sv
module aq_checker
  import pwm_aq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       pwm_out,
  input logic       load,
  input logic [1:0] frc_shadow,
  input logic [1:0] frc_active,
  input rld_e       rld_mode,
  input logic       eff_valid,
  input logic       eff_level,
  input act_e       win_code
);

  // R4
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pwm_out));

  // R2
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !eff_valid && win_code == ACT_TOGGLE) |=> pwm_out != $past(pwm_out));

  // R7
  shadow_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(frc_active));

  // R8
  reload_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rld_mode == RLD_NOW) |=> frc_active == $past(frc_shadow));

  // R9
  force_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && eff_valid) |=> pwm_out == $past(eff_level));

endmodule

bind pwm_action_qual aq_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tb_tick),
  .pwm_out    (pwm_out),
  .load       (load),
  .frc_shadow (frc_shadow),
  .frc_active (frc_active),
  .rld_mode   (rld_mode),
  .eff_valid  (eff_valid),
  .eff_level  (eff_level),
  .win_code   (win_code)
);

// File: tb/pwm_action_qual_test.sv
module pwm_action_qual_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tb_tick = 1'b0;
  logic ev_zero = 1'b0, ev_period = 1'b0, ev_cmpa_up = 1'b0, ev_cmpb_up = 1'b0;
  logic act_wr = 1'b0, frc_wr = 1'b0, rld_wr = 1'b0;
  logic [15:0] act_wdata = '0, frc_wdata = '0, rld_wdata = '0;
  logic out_a, out_b;

  int checks = 0;
  int errors = 0;

  // reference model state, index 0 = channel A copy, 1 = channel B copy
  logic       m_out [2];
  logic [1:0] m_shd [2];
  logic [1:0] m_act [2];
  logic [1:0] m_mode;
  logic [15:0] m_ctl;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_action_qual #(.CHAN_SEL(0)) uut (
    .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick),
    .ev_zero(ev_zero), .ev_period(ev_period), .ev_cmpa_up(ev_cmpa_up), .ev_cmpb_up(ev_cmpb_up),
    .act_wr(act_wr), .act_wdata(act_wdata), .frc_wr(frc_wr), .frc_wdata(frc_wdata),
    .rld_wr(rld_wr), .rld_wdata(rld_wdata), .pwm_out(out_a));

  pwm_action_qual #(.CHAN_SEL(1)) uut_b (
    .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick),
    .ev_zero(ev_zero), .ev_period(ev_period), .ev_cmpa_up(ev_cmpa_up), .ev_cmpb_up(ev_cmpb_up),
    .act_wr(act_wr), .act_wdata(act_wdata), .frc_wr(frc_wr), .frc_wdata(frc_wdata),
    .rld_wr(rld_wr), .rld_wdata(rld_wdata), .pwm_out(out_b));

  task automatic check(input string tag);
    checks++;
    if (out_a !== m_out[0]) begin
      errors++;
      $display("FAIL %s chanA: actual=%b expected=%b", tag, out_a, m_out[0]);
    end
    checks++;
    if (out_b !== m_out[1]) begin
      errors++;
      $display("FAIL %s chanB: actual=%b expected=%b", tag, out_b, m_out[1]);
    end
  endtask

  function automatic logic model_act(input logic cur, input logic [1:0] c);
    if (c == 2'b01) return 1'b0;
    if (c == 2'b10) return 1'b1;
    if (c == 2'b11) return !cur;
    return cur;
  endfunction

  task automatic wr_act(input logic [15:0] v);
    @(negedge clk); act_wr = 1'b1; act_wdata = v;
    @(negedge clk); act_wr = 1'b0;
    m_ctl = v;
  endtask

  task automatic wr_frc(input logic [15:0] v);
    @(negedge clk); frc_wr = 1'b1; frc_wdata = v;
    @(negedge clk); frc_wr = 1'b0;
    m_shd[0] = v[1:0];
    m_shd[1] = v[3:2];
  endtask

  task automatic wr_rld(input logic [1:0] m);
    @(negedge clk); rld_wr = 1'b1; rld_wdata = 16'hFF3F | (16'(m) << 6);
    @(negedge clk); rld_wr = 1'b0;
    m_mode = m;
  endtask

  // one time-base tick carrying events {b,a,p,z}; model then compare
  task automatic step(input logic [3:0] ev, input logic tk, input string tag);
    logic [1:0] code;
    logic ld;
    logic [1:0] eff;
    @(negedge clk);
    tb_tick = tk; ev_zero = ev[0]; ev_period = ev[1]; ev_cmpa_up = ev[2]; ev_cmpb_up = ev[3];
    code = 2'b00;
    if (ev[0]) code = m_ctl[1:0];
    if (ev[1]) code = m_ctl[3:2];
    if (ev[2]) code = m_ctl[5:4];
    if (ev[3]) code = m_ctl[9:8];
    case (m_mode)
      2'b00: ld = ev[0];
      2'b01: ld = ev[1];
      2'b10: ld = ev[0] | ev[1];
      default: ld = 1'b1;
    endcase
    ld = ld & tk;
    for (int c = 0; c < 2; c++) begin
      eff = ld ? m_shd[c] : m_act[c];
      if (ld) m_act[c] = m_shd[c];
      if (tk) begin
        if (eff == 2'b01) m_out[c] = 1'b0;
        else if (eff == 2'b10) m_out[c] = 1'b1;
        else m_out[c] = model_act(m_out[c], code);
      end
    end
    @(negedge clk);
    tb_tick = 1'b0; ev_zero = 1'b0; ev_period = 1'b0; ev_cmpa_up = 1'b0; ev_cmpb_up = 1'b0;
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_out[c] = 1'b0; m_shd[c] = 2'b00; m_act[c] = 2'b00;
    end
    m_mode = 2'b00; m_ctl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset level");
    // R1: actions 00 and no force after reset, so every event holds the low level
    step(4'b1111, 1'b1, "R1 no action after reset");
    step(4'b0001, 1'b1, "R1 no force after reset");

    // R2 and R3: every event against every code from both start levels
    for (int e = 0; e < 4; e++) begin
      for (int cd = 0; cd < 4; cd++) begin
        for (int st = 0; st < 2; st++) begin
          logic [15:0] w;
          int lsb;
          lsb = (e == 3) ? 8 : e * 2;
          w = (e == 0) ? 16'h0000 : (st ? 16'h0002 : 16'h0001);
          if (e == 0) w = st ? 16'h0002 : 16'h0001;
          wr_act(w);
          step(4'b0001, 1'b1, "R2 preset level");
          w = 16'(cd) << lsb;
          wr_act(w);
          step(4'(1 << e), 1'b1, "R2 R3 event code sweep");
        end
      end
    end

    // R3: bits outside the four fields do nothing
    wr_act(16'h0002); step(4'b0001, 1'b1, "R3 preset high");
    wr_act(16'hFCC0);
    for (int e = 0; e < 4; e++) step(4'(1 << e), 1'b1, "R3 unused bits ignored");

    // R4: events with no tick
    wr_act(16'h0333);
    step(4'b1111, 1'b0, "R4 no tick all events");
    step(4'b0001, 1'b0, "R4 no tick zero event");

    // R5: all event combinations, two action words
    for (int k = 0; k < 2; k++) begin
      for (int s = 1; s < 16; s++) begin
        wr_act(16'h0001); step(4'b0001, 1'b1, "R5 preset low");
        wr_act(k ? 16'h0236 : 16'h0019);
        step(4'(s), 1'b1, "R5 coincident priority");
      end
    end

    // R6 R7 R8 R9 R10: every reload mode with every force code
    wr_act(16'h0333);
    for (int m = 0; m < 4; m++) begin
      wr_rld(2'(m));
      for (int f = 0; f < 16; f++) begin
        wr_frc(16'(f));
        step(4'b0000, 1'b1, "R7 R8 plain tick");
        step(4'b0100, 1'b1, "R7 R9 compare tick");
        step(4'b0010, 1'b1, "R8 period tick");
        step(4'b0001, 1'b1, "R6 R8 zero tick");
        step(4'b1111, 1'b1, "R9 all events");
      end
      wr_frc(16'h0000);
      step(4'b0011, 1'b1, "R10 release reload");
      step(4'b0100, 1'b1, "R10 events regain control");
      step(4'b0100, 1'b1, "R10 events regain control");
    end

    // R11: normal then inverted polarity over one period
    wr_rld(2'b00);
    for (int pol = 0; pol < 2; pol++) begin
      wr_act(pol ? 16'h0025 : 16'h001A);
      for (int r = 0; r < 3; r++) begin
        step(4'b0001, 1'b1, "R11 zero");
        step(4'b0000, 1'b1, "R11 count");
        step(4'b0100, 1'b1, "R11 compare");
        step(4'b0010, 1'b1, "R11 period");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule